// File: doc/BRIEF.md
# Running Bit Disparity Monitor

This block watches a serial stream of received bits during a message and keeps a running signed balance of ones against zeros. Each accepted one raises the balance by one and each accepted zero lowers it by one. The balance is checked after every bit, not once when the message ends. When the surplus of ones reaches 25, or the surplus of zeros reaches 27, the block reports a run-length error.

A message-start strobe sets the balance back to zero and clears the error state, so each message is judged on its own. A disable input switches the check off entirely. The error is reported two ways: a single-cycle pulse at the first threshold crossing within a message, and a sticky flag that then stays high until the next message start.

Top module: `disparity_monitor`

## Requirements
- R1: After reset, `err_pulse` and `err_sticky` are 0 and the balance is 0.
- R2: When the balance reaches +25 (ones ahead of zeros by 25) on an accepted bit, `err_pulse` is high for the one cycle that follows that clock edge.
- R3: When the balance reaches -27 (zeros ahead of ones by 27) on an accepted bit, `err_pulse` is high for the one cycle that follows that clock edge.
- R4: While `chk_dis` is 1, the balance is held at 0, `err_sticky` is cleared and `err_pulse` stays 0, whatever bits arrive.
- R5: `err_pulse` fires only once per message. `err_sticky` rises together with it and stays high until a message start or a disable, even if the balance later falls back inside the limits.
- R6: `msg_start` sets the balance to 0 and clears `err_sticky`. A bit accepted in the same cycle counts as the first bit of the new message.
- R7: Cycles with `bit_vld` at 0 leave the balance unchanged, whatever the value of `bit_in`.
- R8: The balance saturates at the limits of its signed `CNT_W`-bit range and never wraps, however long an unbalanced message runs.
- R9: The balance is evaluated after every accepted bit, so a crossing partway through a message is reported when it happens, even if the stream balances out later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Received data bit |
| msg_start | input | 1 | Starts a new message: clears the balance and the sticky flag |
| chk_dis | input | 1 | Turns the check off and holds the balance at 0 |
| err_pulse | output | 1 | One-cycle pulse at the first threshold crossing in a message |
| err_sticky | output | 1 | Error flag held until the next message start |

## Verification
The two functions that can meet in one cycle are the message-start clear and a bit that would carry the old message's balance across a threshold. The bench sets up 24 ones, then in a single cycle asserts `msg_start` together with a one. The expected result is no pulse. The bench then requires exactly 24 further ones before the pulse appears, which shows that the coinciding bit was counted as the first bit of the fresh message.

// File: rtl/disparity_monitor.sv
module disparity_monitor #(
  parameter int ONES_LIM  = 25,
  parameter int ZEROS_LIM = 27,
  parameter int CNT_W     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic msg_start,
  input  logic chk_dis,
  output logic err_pulse,
  output logic err_sticky
);

  localparam logic signed [CNT_W-1:0] CMAX   = CNT_W'((2 ** (CNT_W - 1)) - 1);
  localparam logic signed [CNT_W-1:0] CMIN   = -CMAX - CNT_W'(1);
  localparam logic signed [CNT_W-1:0] POS_TH = CNT_W'(ONES_LIM);
  localparam logic signed [CNT_W-1:0] NEG_TH = CNT_W'(-ZEROS_LIM);
  localparam logic signed [CNT_W-1:0] ONE    = CNT_W'(1);

  logic signed [CNT_W-1:0] diff_q, base, stepped, diff_d;
  logic sticky_base, hit;

  assign base = msg_start ? '0 : diff_q;

  always_comb begin
    stepped = base;
    if (bit_vld) begin
      if (bit_in) stepped = (base == CMAX) ? CMAX : base + ONE;
      else        stepped = (base == CMIN) ? CMIN : base - ONE;
    end
  end

  assign diff_d      = chk_dis ? '0 : stepped;
  assign sticky_base = msg_start ? 1'b0 : err_sticky;
  assign hit         = !chk_dis && (diff_d >= POS_TH || diff_d <= NEG_TH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q     <= '0;
      err_sticky <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      diff_q     <= diff_d;
      err_sticky <= !chk_dis && (sticky_base || hit);
      err_pulse  <= hit && !sticky_base;
    end
  end

  assert_pulse_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (diff_q >= POS_TH || diff_q <= NEG_TH));

  assert_pulse_sets_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  assert_disable_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_dis |=> (diff_q == '0 && !err_pulse && !err_sticky));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  assert_sticky_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> err_pulse);

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_start && !bit_vld) |=> (diff_q == '0 && !err_sticky));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !msg_start && !chk_dis) |=> $stable(diff_q));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_q == CMAX && bit_vld && bit_in && !msg_start && !chk_dis) |=> diff_q == CMAX);

  assert_no_wrap_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_q == CMIN && bit_vld && !bit_in && !msg_start && !chk_dis) |=> diff_q == CMIN);

endmodule

// File: tb/test_disparity_monitor.sv
module test_disparity_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int CMAX = 127;
  localparam int CMIN = -128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 1'b0, bit_in = 1'b0, msg_start = 1'b0, chk_dis = 1'b0;
  logic err_pulse, err_sticky;

  typedef struct {
    logic pulse;
    logic sticky;
    string tag;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nfail = 0;
  int m_diff = 0;
  bit m_sticky = 0;
  bit done = 0;

  disparity_monitor i_disparity_monitor (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .msg_start(msg_start), .chk_dis(chk_dis),
    .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic act_p, input logic act_s, input exp_t e);
    nchk++;
    if (act_p !== e.pulse || act_s !== e.sticky) begin
      nfail++;
      $display("FAIL %s: pulse/sticky actual %b/%b expected %b/%b",
               e.tag, act_p, act_s, e.pulse, e.sticky);
    end
  endtask

  task automatic drive(input bit v, input bit b, input bit st, input bit dis, input string tag);
    exp_t e;
    bit sb, hit;
    @(negedge clk);
    bit_vld = v; bit_in = b; msg_start = st; chk_dis = dis;
    if (dis) begin
      m_diff = 0; m_sticky = 0; e.pulse = 0;
    end else begin
      if (st) m_diff = 0;
      sb = st ? 1'b0 : m_sticky;
      if (v) begin
        if (b) m_diff = (m_diff == CMAX) ? CMAX : m_diff + 1;
        else   m_diff = (m_diff == CMIN) ? CMIN : m_diff - 1;
      end
      hit = (m_diff >= 25) || (m_diff <= -27);
      e.pulse = hit && !sb;
      m_sticky = sb || hit;
    end
    e.sticky = m_sticky;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run(input int n, input bit b, input string tag);
    for (int i = 0; i < n; i++) drive(1, b, 0, 0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (q.size() > 0) begin
        e = q.pop_front();
        check(err_pulse, err_sticky, e);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : stim
    exp_t r;
    #(CLK_PERIOD * 2 + 1);
    r.pulse = 0; r.sticky = 0; r.tag = "R1 reset";
    check(err_pulse, err_sticky, r);
    @(negedge clk); rst_n = 1'b1;

    // R2: positive limit, then R5 single pulse and hold
    run(24, 1, "R2 below +limit");
    run(1, 1, "R2 at +limit");
    run(10, 1, "R5 no repeat");
    run(40, 0, "R5 sticky holds");

    // R6 clear, R3 negative limit
    drive(0, 0, 1, 0, "R6 start clears");
    run(26, 0, "R3 below -limit");
    run(1, 0, "R3 at -limit");
    run(3, 1, "R5 hold after -limit");

    // R7: invalid bits ignored
    drive(0, 0, 1, 0, "R6 start");
    run(20, 1, "R7 ones");
    for (int i = 0; i < 30; i++) drive(0, 1, 0, 0, "R7 ignored bits");
    run(4, 1, "R7 +24 no pulse");
    run(1, 1, "R7 +25 pulse");

    // R9: mid-message crossing after balanced prefix
    drive(0, 0, 1, 0, "R6 start");
    for (int i = 0; i < 20; i++) drive(1, i[0], 0, 0, "R9 balanced");
    run(25, 1, "R9 mid-message crossing");
    run(25, 0, "R9 rebalance keeps flag");

    // R4: disable
    for (int i = 0; i < 40; i++) drive(1, 1, 0, 1, "R4 disabled");
    drive(0, 0, 1, 1, "R4 disabled start");
    run(24, 1, "R4 re-enabled from zero");
    run(1, 1, "R4 re-enabled pulse");

    // R6: start coinciding with a would-be crossing bit
    drive(0, 0, 1, 0, "R6 start");
    run(24, 1, "R6 setup");
    drive(1, 1, 1, 0, "R6 start with bit");
    run(23, 1, "R6 new message below");
    run(1, 1, "R6 new message pulse");

    // R8: long unbalanced run, then negative long run
    drive(0, 0, 1, 0, "R6 start");
    run(300, 1, "R8 saturate high");
    drive(0, 0, 1, 0, "R6 start");
    run(300, 0, "R8 saturate low");

    repeat (3) @(negedge clk);
    bit_vld = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule